// File: doc/BRIEF.md
# Diagonal Wavefront Allocator

This block matches N requesters to N resources in a single combinational pass. The request matrix has one bit per requester/resource pair. The cell at row `r` and column `c` lies on diagonal `(c - r) mod N`. No two cells on one diagonal share a row or a column, so an entire diagonal can be granted at once without conflict.

Each allocation visits the diagonals in order, starting at a priority diagonal. A diagonal's requests are granted only if their row and column are still free. Each grant consumes its row and column for all later diagonals.

The wraparound from the last diagonal back to the first would form a combinational loop. To avoid it, the diagonals are laid out as an unrolled chain of 2N-1 stages. A window of N consecutive stages, beginning at the priority diagonal, is switched on. The priority diagonal moves forward by one every cycle in which the request strobe is high, so no requester pair is starved. The grant appears combinationally in the same cycle as the request.

Top module: `wf_alloc`

## Requirements
- R1: After reset the priority diagonal is 0. With a full request matrix, the first strobed cycle grants exactly the cells where row equals column.
- R2: While `reqValid` is low, `gntMatrix` is all zero, whatever `reqMatrix` holds.
- R3: Every asserted grant bit has its request bit asserted. Bit index is `row*N + col`.
- R4: At most one grant is asserted in any row and in any column.
- R5: Every requested cell on the current priority diagonal is granted.
- R6: The grant equals the result of visiting diagonals p, p+1, …, p+N-1 (mod N), where p is the priority diagonal. On each diagonal, every request whose row and column are both still free is granted.
- R7: The priority diagonal advances by one, modulo N, after each cycle with `reqValid` high, and holds otherwise.
- R8: An all-zero request matrix with `reqValid` high yields an all-zero grant, and the priority diagonal still advances.
- R9: With a full request matrix, the grant is exactly the N cells of the current priority diagonal.
- R10: The grant is maximal: every requested but ungranted cell has a grant elsewhere in its row or its column.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe; enables the grant and advances the priority |
| reqMatrix | input | N*N | Request bits, index row*N+col |
| gntMatrix | output | N*N | Grant bits, index row*N+col |

## Verification
The only state is the priority diagonal. A wrong value cannot be seen directly. It shows up as a grant pattern shifted to a different diagonal, most plainly under a full request matrix, where the whole granted diagonal moves. It also shows up as a mismatch against the ordered-diagonal reference on random requests. Because the grant is combinational, a stuck or mis-stepped priority register is exposed in the first strobed cycle after the fault. A fault in the token chain shows at once, as a double grant in a row or column, or as a non-maximal result.

// File: rtl/wf_pkg.sv
package wf_pkg;
  // Strobes from control to the diagonal array.
  typedef struct packed {
    logic gate;     // enable the diagonal window this cycle
    logic advance;  // move priority diagonal at the next edge
  } wfStrobe_t;
endpackage

// File: rtl/wf_ctrl.sv
module wf_ctrl
  import wf_pkg::*;
#(
  parameter int N  = 4,
  parameter int PW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          reqValid,
  output wfStrobe_t     strobe,
  output logic [PW-1:0] prioDiag
);
  localparam logic [PW-1:0] LastDiag = PW'(N - 1);

  always_comb begin
    strobe.gate    = reqValid;
    strobe.advance = reqValid;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prioDiag <= '0;
    end else if (strobe.advance) begin
      if (prioDiag == LastDiag) prioDiag <= '0;
      else                      prioDiag <= prioDiag + 1'b1;
    end
  end
endmodule

// File: rtl/wf_window.sv
module wf_window
  import wf_pkg::*;
#(
  parameter int N  = 4,
  parameter int PW = (N > 1) ? $clog2(N) : 1,
  parameter int S  = 2 * N - 1
) (
  input  wfStrobe_t     strobe,
  input  logic [PW-1:0] prioDiag,
  output logic [S-1:0]  stageOn
);
  // Stage k is on when prioDiag <= k < prioDiag + N.
  for (genvar k = 0; k < S; k++) begin : g_win
    logic [PW:0] lo;
    assign lo = {1'b0, prioDiag};
    assign stageOn[k] = strobe.gate && ((PW+1)'(k) >= lo) && ((PW+1)'(k) < lo + (PW+1)'(N));
  end
endmodule

// File: rtl/wf_array.sv
module wf_array #(
  parameter int N = 4,
  parameter int S = 2 * N - 1,
  parameter int M = N * N
) (
  input  logic [S-1:0] stageOn,
  input  logic [M-1:0] reqMatrix,
  output logic [M-1:0] gntMatrix
);
  // Unrolled chain: stage k serves diagonal k mod N.
  for (genvar k = 0; k < S; k++) begin : stg
    localparam int D = k % N;
    logic [N-1:0] rowIn, colIn, rowOut, colOut, hit, colHit;
    if (k == 0) begin : g_first
      assign rowIn = '1;
      assign colIn = '1;
    end else begin : g_next
      assign rowIn = stg[k-1].rowOut;
      assign colIn = stg[k-1].colOut;
    end
    for (genvar r = 0; r < N; r++) begin : g_cell
      localparam int C = (r + D) % N;
      assign hit[r]    = stageOn[k] & reqMatrix[r*N + C] & rowIn[r] & colIn[C];
      assign colHit[C] = hit[r];
    end
    assign rowOut = rowIn & ~hit;
    assign colOut = colIn & ~colHit;
  end

  // Fold the two copies of each diagonal back onto the matrix.
  for (genvar r = 0; r < N; r++) begin : g_row
    for (genvar c = 0; c < N; c++) begin : g_col
      localparam int D = (c - r + N) % N;
      if (D + N < S) begin : g_two
        assign gntMatrix[r*N + c] = stg[D].hit[r] | stg[D+N].hit[r];
      end else begin : g_one
        assign gntMatrix[r*N + c] = stg[D].hit[r];
      end
    end
  end
endmodule

// File: rtl/wf_alloc.sv
module wf_alloc
  import wf_pkg::*;
#(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         reqValid,
  input  logic [N*N-1:0] reqMatrix,
  output logic [N*N-1:0] gntMatrix
);
  localparam int PW = (N > 1) ? $clog2(N) : 1;
  localparam int S  = 2 * N - 1;

  wfStrobe_t     strobe;
  logic [PW-1:0] prioDiag;
  logic [S-1:0]  stageOn;

  wf_ctrl #(.N(N), .PW(PW)) uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid),
    .strobe(strobe), .prioDiag(prioDiag)
  );

  wf_window #(.N(N), .PW(PW), .S(S)) uWin (
    .strobe(strobe), .prioDiag(prioDiag), .stageOn(stageOn)
  );

  wf_array #(.N(N), .S(S), .M(N*N)) uArr (
    .stageOn(stageOn), .reqMatrix(reqMatrix), .gntMatrix(gntMatrix)
  );
endmodule

// File: rtl/wf_alloc_chk.sv
module wf_alloc_chk #(
  parameter int N = 4
) (
  input logic         clk,
  input logic         rstN,
  input logic         reqValid,
  input logic [N*N-1:0] reqMatrix,
  input logic [N*N-1:0] gntMatrix
);
  localparam int PW = (N > 1) ? $clog2(N) : 1;

  function automatic logic matchOk(input logic [N*N-1:0] g);
    logic ok = 1'b1;
    for (int i = 0; i < N; i++) begin
      int rc = 0;
      int cc = 0;
      for (int j = 0; j < N; j++) begin
        rc += int'(g[i*N + j]);
        cc += int'(g[j*N + i]);
      end
      if (rc > 1 || cc > 1) ok = 1'b0;
    end
    return ok;
  endfunction

  function automatic logic maximalOk(input logic [N*N-1:0] q, input logic [N*N-1:0] g);
    logic ok = 1'b1;
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++)
        if (q[r*N + c] && !g[r*N + c]) begin
          logic taken = 1'b0;
          for (int j = 0; j < N; j++)
            if (g[r*N + j] || g[j*N + c]) taken = 1'b1;
          if (!taken) ok = 1'b0;
        end
    return ok;
  endfunction

  function automatic logic [N*N-1:0] diagMask(input logic [PW-1:0] p);
    logic [N*N-1:0] m = '0;
    for (int r = 0; r < N; r++) m[r*N + ((r + int'(p)) % N)] = 1'b1;
    return m;
  endfunction

  logic [PW-1:0] expPrio;
  always_ff @(posedge clk) begin
    if (!rstN) expPrio <= '0;
    else if (reqValid) expPrio <= (int'(expPrio) == N - 1) ? '0 : expPrio + 1'b1;
  end

  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |-> gntMatrix == '0);

  // R3
  grant_has_request_chk: assert property (@(posedge clk) disable iff (!rstN)
    (gntMatrix & ~reqMatrix) == '0);

  // R4
  one_per_line_chk: assert property (@(posedge clk) disable iff (!rstN)
    matchOk(gntMatrix));

  // R10
  maximal_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> maximalOk(reqMatrix, gntMatrix));

  // R9
  full_is_diag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqMatrix == '1) |-> gntMatrix == diagMask(expPrio));
endmodule

bind wf_alloc wf_alloc_chk #(.N(N)) uChk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid),
  .reqMatrix(reqMatrix), .gntMatrix(gntMatrix)
);

// File: tb/sim_wf_alloc.sv
module sim_wf_alloc;
  localparam int N = 4;
  localparam int M = N * N;
  localparam int ClkPeriod = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic [M-1:0] reqMatrix = '0;
  logic [M-1:0] gntMatrix;

  int checks = 0;
  int errors = 0;
  int prio = 0;
  bit done = 1'b0;

  always #(ClkPeriod/2) clk = ~clk;

  wf_alloc #(.N(N)) u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid),
    .reqMatrix(reqMatrix), .gntMatrix(gntMatrix)
  );

  function automatic logic [M-1:0] refAlloc(input logic [M-1:0] q, input int p);
    logic [N-1:0] rowFree = '1;
    logic [N-1:0] colFree = '1;
    logic [M-1:0] g = '0;
    for (int s = 0; s < N; s++) begin
      int d = (p + s) % N;
      for (int r = 0; r < N; r++) begin
        int c = (r + d) % N;
        if (q[r*N + c] && rowFree[r] && colFree[c]) begin
          g[r*N + c] = 1'b1;
          rowFree[r] = 1'b0;
          colFree[c] = 1'b0;
        end
      end
    end
    return g;
  endfunction

  function automatic logic [M-1:0] diagOf(input int p);
    logic [M-1:0] m = '0;
    for (int r = 0; r < N; r++) m[r*N + ((r + p) % N)] = 1'b1;
    return m;
  endfunction

  task automatic check(input string tag, input logic [M-1:0] got, input logic [M-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  // Drive one cycle, check the combinational grant at the falling edge.
  task automatic step(input string tag, input logic v, input logic [M-1:0] q);
    @(posedge clk); #1;
    reqValid = v;
    reqMatrix = q;
    @(negedge clk);
    check(tag, gntMatrix, v ? refAlloc(q, prio) : '0);
    if (v) prio = (prio + 1) % N;
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R2 reset quiet", gntMatrix, '0);
    rstN = 1'b1;

    // R1 / R9: first strobe after reset grants main diagonal
    @(posedge clk); #1;
    reqValid = 1'b1; reqMatrix = '1;
    @(negedge clk);
    check("R1 first diagonal", gntMatrix, diagOf(0));
    prio = 1;

    // R9 full matrix across all rotations
    for (int i = 0; i < N + 1; i++) begin
      step("R9 full", 1'b1, '1);
    end
    check("R9 full diag shape", refAlloc('1, 2), diagOf(2));

    // R7 hold while idle, R2 quiet with requests present
    step("R2 idle", 1'b0, '1);
    step("R2 idle", 1'b0, 16'h1234);
    @(posedge clk); #1;
    reqValid = 1'b1; reqMatrix = '1;
    @(negedge clk);
    check("R7 hold then resume", gntMatrix, diagOf(prio));
    prio = (prio + 1) % N;

    // R8 empty matrix advances priority
    step("R8 empty", 1'b1, '0);
    @(posedge clk); #1;
    reqValid = 1'b1; reqMatrix = '1;
    @(negedge clk);
    check("R8 advance after empty", gntMatrix, diagOf(prio));
    prio = (prio + 1) % N;

    // R5 single-column contention and single cell
    step("R5 column", 1'b1, 16'h1111);
    step("R5 single", 1'b1, 16'h0040);
    step("R6 row", 1'b1, 16'h000F);
    step("R6 anti", 1'b1, 16'h1248);

    // R6 / R10 / R3 / R4 random
    for (int i = 0; i < 400; i++) begin
      logic [M-1:0] q;
      logic v;
      q = M'($urandom);
      if (i % 3 == 0) q = q & M'($urandom);
      if (i % 5 == 0) q = q | M'($urandom);
      v = ($urandom % 8) != 0;
      step("R6 random", v, q);
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule